// File: doc/BRIEF.md
# Ethernet multicast hash address filter

This block decides whether a received frame should be kept, based only on its 48-bit destination address. A caller presents the address with a one-cycle strobe. The block runs an Ethernet CRC-32 over the six address bytes, one byte per clock, and uses the top bits of the result as an index into a bit table that software programs. The pass or drop verdict comes back with a one-cycle done pulse.

Three independent mode flags in a control word steer the verdict. Promiscuous mode keeps every frame. Pass-all-multicast mode keeps every multicast frame. Hash-multicast mode keeps a multicast frame only when its table bit is set. The number of table bins (64, 128 or 256) is fixed at build time by a parameter. A read-only capability field reports the bin count. Control, table and capability are reached through a simple word-wide register port with a combinational read path.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset the control word and every table word read as 0, and result_done is low.
- R2: The control word at offset 0x08 is a full 32-bit read/write word. The promiscuous flag is bit 0, hash-multicast is bit 2 and pass-all-multicast is bit 4. A read-modify-write of one flag leaves every other bit as it was.
- R3: Table word i (i < BINS/32) is read/write at offset 0x10 + 4*i. Any other offset reads 0 and ignores writes. This includes word offsets beyond the configured size and unaligned offsets.
- R4: Offset 0x40 reads the capability code log2(BINS/32) in bits [25:24], with all other bits 0. The code is 1, 2 or 3 for 64, 128 or 256 bins. Writes to 0x40 have no effect.
- R5: The hash index is formed in three steps. First, a reflected CRC-32 (polynomial 0xEDB88320, initial value all ones) runs over dest_addr[47:40] first and dest_addr[7:0] last, each byte taken LSB first. Second, the result is complemented and bit-reversed. Third, the top log2(BINS) bits are kept. Index bits above bit 4 pick the table word, and bits [4:0] pick the bit within it.
- R6: With the promiscuous flag set, every lookup passes.
- R7: result_done is a one-cycle pulse seven clock cycles after an accepted strobe. Strobes sampled during those seven cycles are ignored. A strobe presented in the cycle where result_done is high is accepted.
- R8: A unicast address (dest_addr[40] = 0) is dropped whenever the promiscuous flag is clear.
- R9: A multicast address (dest_addr[40] = 1, broadcast included) passes when pass-all-multicast is set and promiscuous is clear, whatever the hash-multicast flag and the table hold.
- R10: In hash-multicast mode alone, a multicast address passes exactly when its indexed table bit is 1. With all table words set to all ones, this mode gives the same verdicts as pass-all-multicast.
- R11: With no mode flag set, multicast addresses are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_valid | input | 1 | Strobe: dest_addr holds an address to check |
| dest_addr | input | 48 | Destination address, first transmitted byte in [47:40] |
| result_done | output | 1 | One-cycle pulse marking a valid verdict |
| result_pass | output | 1 | Verdict: 1 keep, 0 drop (read while result_done is high) |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |

## Verification
The assertions check several properties on every cycle. They check the done timing against an independent strobe counter, and they check that the pulse is never longer than one cycle. They also enforce the mode priorities that need no hash: promiscuous always passes, unicast drops without promiscuous, pass-all-multicast keeps multicast, and no mode drops multicast. Whether the right table bit is selected depends on the CRC and the table contents, so only the bench's reference model can show it. The same holds for the all-ones equivalence, the register map and read-modify-write behaviour, and the ignoring of strobes during a lookup, all compared against the model on every clock.

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int BINS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        addr_valid,
  input  logic [47:0] dest_addr,
  output logic        result_done,
  output logic        result_pass,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int HASH_W   = $clog2(BINS);
  localparam int NWORDS   = BINS / 32;
  localparam int CAP_CODE = HASH_W - 5;
  localparam logic [7:0] CTRL_OFF = 8'h08;
  localparam logic [7:0] TBL_OFF  = 8'h10;
  localparam logic [7:0] CAP_OFF  = 8'h40;
  localparam int PROMISC_BIT = 0;
  localparam int HASHMC_BIT  = 2;
  localparam int ALLMC_BIT   = 4;
  localparam logic [31:0] POLY = 32'hEDB88320;

  logic [31:0]     ctrl_q;
  logic [BINS-1:0] tbl_q;
  logic            busy;
  logic [2:0]      cnt;
  logic [47:0]     addr_q;
  logic            mc_q;
  logic [31:0]     crc_q;
  logic            done_q;
  logic            pass_q;
  logic [HASH_W-1:0] hash_idx;
  logic            verdict;

  function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] b);
    logic [31:0] c;
    c = c_in ^ {24'd0, b};
    for (int k = 0; k < 8; k++)
      c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
    return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tbl_q  <= '0;
    end else if (reg_we) begin
      if (reg_addr == CTRL_OFF) ctrl_q <= reg_wdata;
      for (int i = 0; i < NWORDS; i++)
        if (reg_addr == 8'(int'(TBL_OFF) + 4 * i)) tbl_q[i*32 +: 32] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_OFF) reg_rdata = ctrl_q;
    if (reg_addr == CAP_OFF)  reg_rdata = {6'd0, 2'(CAP_CODE), 24'd0};
    for (int i = 0; i < NWORDS; i++)
      if (reg_addr == 8'(int'(TBL_OFF) + 4 * i)) reg_rdata = tbl_q[i*32 +: 32];
  end

  always_comb
    for (int k = 0; k < HASH_W; k++)
      hash_idx[HASH_W-1-k] = ~crc_q[k];

  always_comb begin
    if (ctrl_q[PROMISC_BIT])     verdict = 1'b1;
    else if (!mc_q)              verdict = 1'b0;
    else if (ctrl_q[ALLMC_BIT])  verdict = 1'b1;
    else if (ctrl_q[HASHMC_BIT]) verdict = tbl_q[hash_idx];
    else                         verdict = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      addr_q <= '0;
      mc_q   <= 1'b0;
      crc_q  <= '1;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy) begin
        if (addr_valid) begin
          busy   <= 1'b1;
          cnt    <= '0;
          addr_q <= dest_addr;
          mc_q   <= dest_addr[40];
          crc_q  <= '1;
        end
      end else if (cnt != 3'd6) begin
        crc_q  <= crc_step(crc_q, addr_q[47:40]);
        addr_q <= addr_q << 8;
        cnt    <= cnt + 3'd1;
      end else begin
        busy   <= 1'b0;
        done_q <= 1'b1;
        pass_q <= verdict;
      end
    end
  end

  assign result_done = done_q;
  assign result_pass = pass_q;
endmodule

// File: rtl/mcast_hash_filter_chk.sv
module mcast_hash_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        addr_valid,
  input logic        result_done,
  input logic        result_pass,
  input logic [31:0] ctrl_q,
  input logic        mc_q
);
  logic [2:0] ck_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_cnt <= '0;
    else if (ck_cnt != 3'd0) ck_cnt <= ck_cnt - 3'd1;
    else if (addr_valid) ck_cnt <= 3'd7;
  end

  p_done_on_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_cnt == 3'd1) |=> result_done);
  p_done_only_on_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_cnt != 3'd1) |=> !result_done);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    result_done |=> !result_done);
  p_promisc_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (result_done && $past(ctrl_q[0])) |-> result_pass);
  p_unicast_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (result_done && !$past(ctrl_q[0]) && !mc_q) |-> !result_pass);
  p_allmc_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (result_done && !$past(ctrl_q[0]) && mc_q && $past(ctrl_q[4])) |-> result_pass);
  p_nomode_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (result_done && mc_q && ($past(ctrl_q[4:0] & 5'h15) == 5'h00)) |-> !result_pass);
endmodule

bind mcast_hash_filter mcast_hash_filter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .result_done(result_done),
  .result_pass(result_pass), .ctrl_q(ctrl_q), .mc_q(mc_q)
);

// File: tb/mcast_hash_filter_tb_top.sv
module mcast_hash_filter_tb_top;
  localparam int BINS = 128;
  localparam int HW   = $clog2(BINS);
  localparam int NW   = BINS / 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_valid = 1'b0;
  logic [47:0] dest_addr = '0;
  logic result_done, result_pass;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mcast_hash_filter #(.BINS(BINS)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .dest_addr(dest_addr),
    .result_done(result_done), .result_pass(result_pass), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  logic [31:0] m_ctrl;
  logic [31:0] m_tbl [NW];
  int          m_cnt;
  logic [47:0] m_addr;
  logic        e_done, e_pass;
  string       e_tag;

  function automatic int ref_index(input logic [47:0] a);
    logic [31:0] n;
    logic [7:0] b;
    logic top;
    n = 32'hFFFFFFFF;
    for (int by = 0; by < 6; by++) begin
      b = a[47 - 8*by -: 8];
      for (int k = 0; k < 8; k++) begin
        top = n[31] ^ b[k];
        n = n << 1;
        if (top) n = n ^ 32'h04C11DB7;
      end
    end
    n = ~n;
    return int'(n >> (32 - HW));
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a == 8'h08) return m_ctrl;
    if (a == 8'h40) return {6'd0, 2'(HW - 5), 24'd0};
    for (int i = 0; i < NW; i++)
      if (int'(a) == 16 + 4*i) return m_tbl[i];
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = '0;
      for (int i = 0; i < NW; i++) m_tbl[i] = '0;
      m_cnt = 0;
      e_done = 1'b0;
      e_pass = 1'b0;
      e_tag = "R1";
    end else begin
      e_done = 1'b0;
      if (m_cnt > 0) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          int idx;
          e_done = 1'b1;
          idx = ref_index(m_addr);
          if (m_ctrl[0]) begin e_pass = 1'b1; e_tag = "R6"; end
          else if (!m_addr[40]) begin e_pass = 1'b0; e_tag = "R8"; end
          else if (m_ctrl[4]) begin e_pass = 1'b1; e_tag = "R9"; end
          else if (m_ctrl[2]) begin e_pass = m_tbl[idx / 32][idx % 32]; e_tag = "R5 R10"; end
          else begin e_pass = 1'b0; e_tag = "R11"; end
        end
      end else if (addr_valid) begin
        m_cnt = 7;
        m_addr = dest_addr;
      end
      if (reg_we) begin
        if (reg_addr == 8'h08) m_ctrl = reg_wdata;
        for (int i = 0; i < NW; i++)
          if (int'(reg_addr) == 16 + 4*i) m_tbl[i] = reg_wdata;
      end
    end
  end

  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      logic [31:0] exp_rd;
      checks++;
      if (result_done !== e_done) begin
        errors++;
        $display("FAIL R7 result_done actual=%0b expected=%0b", result_done, e_done);
      end
      if (e_done) begin
        checks++;
        if (result_pass !== e_pass) begin
          errors++;
          $display("FAIL %s result_pass actual=%0b expected=%0b addr=%h", e_tag, result_pass, e_pass, m_addr);
        end
      end
      exp_rd = model_read(reg_addr);
      checks++;
      if (reg_rdata !== exp_rd) begin
        errors++;
        $display("FAIL %s reg_rdata @%h actual=%h expected=%h",
                 (reg_addr == 8'h08) ? "R2" : (reg_addr == 8'h40) ? "R4" : "R3",
                 reg_addr, reg_rdata, exp_rd);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [31:0] exp_v, input string tag);
    @(negedge clk);
    reg_addr = a;
    #2;
    checks++;
    if (reg_rdata !== exp_v) begin
      errors++;
      $display("FAIL %s read @%h actual=%h expected=%h", tag, a, reg_rdata, exp_v);
    end
  endtask

  task automatic look(input logic [47:0] a);
    @(negedge clk);
    addr_valid = 1'b1; dest_addr = a;
    @(negedge clk);
    addr_valid = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic look_many(input int n);
    for (int j = 0; j < n; j++) look({$urandom, $urandom} & 48'hFFFFFFFFFFFF);
    for (int j = 0; j < n; j++) look(({$urandom, $urandom} & 48'hFFFFFFFFFFFF) | 48'h0100_0000_0000);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int idx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    checks++;
    if (result_done !== 1'b0) begin errors++; $display("FAIL R1 result_done actual=%0b expected=0", result_done); end
    rd_check(8'h08, 32'd0, "R1");
    for (int i = 0; i < NW; i++) rd_check(8'(16 + 4*i), 32'd0, "R1");
    // R4 capability, writes ignored
    rd_check(8'h40, {6'd0, 2'(HW - 5), 24'd0}, "R4");
    wr(8'h40, 32'hFFFFFFFF);
    rd_check(8'h40, {6'd0, 2'(HW - 5), 24'd0}, "R4");
    // R3 table words and out-of-range offsets
    for (int i = 0; i < NW; i++) wr(8'(16 + 4*i), 32'h1111_0000 * (i + 1) + 32'h0000_A5C3);
    for (int i = 0; i < NW; i++) rd_check(8'(16 + 4*i), 32'h1111_0000 * (i + 1) + 32'h0000_A5C3, "R3");
    wr(8'(16 + 4*NW), 32'hDEADBEEF);
    rd_check(8'(16 + 4*NW), 32'd0, "R3");
    wr(8'h11, 32'hDEADBEEF);
    rd_check(8'h11, 32'd0, "R3");
    rd_check(8'h10, 32'h1111_A5C3, "R3");
    // R11 no mode
    look(48'hFFFF_FFFF_FFFF);
    look_many(6);
    // R2 control word with read-modify-write
    wr(8'h08, 32'hA5A5_0000);
    rd_check(8'h08, 32'hA5A5_0000, "R2");
    @(negedge clk); reg_addr = 8'h08; #2; v = reg_rdata;
    wr(8'h08, v | 32'h4);
    rd_check(8'h08, 32'hA5A5_0004, "R2");
    // R5 R10 hash mode with programmed table
    look_many(20);
    idx = ref_index(48'h0100_5E00_00FB);
    for (int i = 0; i < NW; i++) wr(8'(16 + 4*i), 32'd0);
    wr(8'(16 + 4*(idx / 32)), 32'd1 << (idx % 32));
    look(48'h0100_5E00_00FB);
    look(48'h3333_0000_0001);
    look_many(10);
    // R10 all ones equals pass-all
    for (int i = 0; i < NW; i++) wr(8'(16 + 4*i), 32'hFFFFFFFF);
    look_many(10);
    // R9 pass-all over hash, with empty table
    for (int i = 0; i < NW; i++) wr(8'(16 + 4*i), 32'd0);
    wr(8'h08, 32'hA5A5_0014);
    look_many(10);
    // R6 promiscuous
    wr(8'h08, 32'h0000_0001);
    look_many(8);
    // R7 strobe held during lookups
    wr(8'h08, 32'h0000_0004);
    for (int i = 0; i < NW; i++) wr(8'(16 + 4*i), 32'h5A5A_C3C3 ^ (32'h0F0F_0000 * i));
    for (int j = 0; j < 24; j++) begin
      @(negedge clk);
      addr_valid = 1'b1;
      dest_addr = ({$urandom, $urandom} & 48'hFFFFFFFFFFFF) | 48'h0100_0000_0000;
    end
    @(negedge clk);
    addr_valid = 1'b0;
    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule